// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the access address for four-beat bursts on a synchronous SRAM. A burst opens when one of two active-low address strobes is low at a clock edge. The processor-side strobe is gated by the primary chip enable. The controller-side strobe loads the address whatever that enable does. The two low address bits then step through the burst, either in linear order (add one, modulo the burst length) or in interleaved order (start value XOR beat number). The upper bits stay at the loaded value.

With both strobes high, an active-low advance input steps the burst by one beat. With advance high, the address holds and the cycle becomes a wait cycle. The block also reports whether the current cycle is selected, whether it is the first beat of a burst, and whether a write is refused on it. A burst opened by the processor strobe is always a read, so its first cycle refuses a write.

All outputs are registered and take effect in the cycle after the clock edge that sampled the inputs. The one exception is the ordering input, which maps the beat count to address bits combinationally.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset (rst_ni low), addr_o is 0, sel_o is 0, burst_start_o is 0 and wr_block_o is 1.
- R2: adsp_ni low with ce1_ni low at an edge loads addr_i. The access is selected when ce2_i is high and ce3_ni is low. burst_start_o is 1 in the following cycle only if the access is selected.
- R3: With ce1_ni high, adsp_ni is masked, and the edge behaves as if adsp_ni were high.
- R4: adsc_ni low, when the processor strobe is not taken, loads addr_i whatever ce1_ni is. The access is selected only for ce1_ni low, ce2_i high and ce3_ni low; otherwise the cycle is a deselect that still holds the loaded address.
- R5: When both strobes are low and ce1_ni is low, the processor strobe wins, so the cycle is handled as an ADSP-initiated burst start and refuses a write.
- R6: ce2_i and ce3_ni have no effect on an edge where no strobe is taken.
- R7: With ilv_order_i low (linear), addr_o[1:0] equals the start value plus the beat count, modulo 4.
- R8: With ilv_order_i high (interleaved), addr_o[1:0] equals the start value XOR the beat count.
- R9: With both strobes high and the access selected, adv_ni low advances the beat count by one, and adv_ni high holds it as a wait cycle. The upper address bits change only when an address is loaded.
- R10: After the fourth beat, with adv_ni still low, the address wraps back to the first address of the burst.
- R11: wr_block_o is 1 in the cycle after a selected ADSP-initiated load and 0 on selected cycles that follow it. It is 1 whenever sel_o is 0.
- R12: While deselected with no strobe taken, adv_ni has no effect on addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| adsp_ni | input | 1 | Processor address strobe, active low, masked by ce1_ni |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce3_ni | input | 1 | Secondary chip enable, active low |
| ilv_order_i | input | 1 | 1 selects interleaved order, 0 selects linear |
| addr_o | output | ADDR_W | Internal access address |
| sel_o | output | 1 | Current cycle is selected |
| burst_start_o | output | 1 | First beat of a selected burst |
| wr_block_o | output | 1 | A write is refused on this cycle |

## Verification
The bench builds the block with ADDR_W=8 and BURST_BITS=2. The 8-bit address keeps the expected values readable while still leaving six upper bits whose stability can be checked. Two burst bits give the four-beat wrap in both orders. Start values of 01, 10 and 11 bring the linear carry out of bit 1 within reach, along with the XOR patterns that differ from it. Deselect with a loaded address, strobe masking and strobe priority are all reached within a single vector walk.

// File: rtl/bab_pkg.sv
package bab_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } bab_op_e;
endpackage

// File: rtl/bab_strobe_dec.sv
module bab_strobe_dec
  import bab_pkg::*;
(
  input  logic    adsp_ni,
  input  logic    adsc_ni,
  input  logic    adv_ni,
  input  logic    ce1_ni,
  input  logic    ce2_i,
  input  logic    ce3_ni,
  input  logic    sel_q_i,
  output bab_op_e op_o,
  output logic    take_p_o,
  output logic    sel_new_o
);
  logic take_c;

  // processor strobe gated by ce1; it wins over the controller strobe
  assign take_p_o  = !adsp_ni && !ce1_ni;
  assign take_c    = !adsc_ni && !take_p_o;
  assign sel_new_o = !ce1_ni && ce2_i && !ce3_ni;

  always_comb begin
    if (take_p_o || take_c)    op_o = OP_LOAD;
    else if (sel_q_i && !adv_ni) op_o = OP_STEP;
    else                       op_o = OP_HOLD;
  end
endmodule

// File: rtl/bab_beat_ctr.sv
module bab_beat_ctr
  import bab_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  bab_op_e               op_i,
  input  logic [BURST_BITS-1:0] start_i,
  input  logic                  ilv_i,
  output logic [BURST_BITS-1:0] lo_o
);
  logic [BURST_BITS-1:0] base_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD: begin
          base_q <= start_i;
          cnt_q  <= '0;
        end
        OP_STEP: cnt_q <= cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign lo_o = ilv_i ? (base_q ^ cnt_q) : (base_q + cnt_q);

  // R9 R10
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_STEP |=> cnt_q == $past(cnt_q) + 1'b1);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> $stable(cnt_q) && $stable(base_q));
  // R2 R4
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOAD |=> cnt_q == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bab_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_ni,
  input  logic              adsc_ni,
  input  logic              adv_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              ilv_order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o,
  output logic              burst_start_o,
  output logic              wr_block_o
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  bab_op_e               op;
  logic                  take_p, sel_new;
  logic [HI_W-1:0]       hi_q;
  logic [BURST_BITS-1:0] lo;
  logic                  sel_q, start_q, pread_q;

  bab_strobe_dec u_dec (
    .adsp_ni  (adsp_ni),
    .adsc_ni  (adsc_ni),
    .adv_ni   (adv_ni),
    .ce1_ni   (ce1_ni),
    .ce2_i    (ce2_i),
    .ce3_ni   (ce3_ni),
    .sel_q_i  (sel_q),
    .op_o     (op),
    .take_p_o (take_p),
    .sel_new_o(sel_new)
  );

  bab_beat_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .start_i(addr_i[BURST_BITS-1:0]),
    .ilv_i  (ilv_order_i),
    .lo_o   (lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      sel_q   <= 1'b0;
      start_q <= 1'b0;
      pread_q <= 1'b0;
    end else if (op == OP_LOAD) begin
      hi_q    <= addr_i[ADDR_W-1:BURST_BITS];
      sel_q   <= sel_new;
      start_q <= sel_new;
      pread_q <= take_p && sel_new;
    end else begin
      start_q <= 1'b0;
      pread_q <= 1'b0;
    end
  end

  assign addr_o        = {hi_q, lo};
  assign sel_o         = sel_q;
  assign burst_start_o = start_q;
  assign wr_block_o    = !sel_q || pread_q;

  // R2 R4
  start_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_o |-> sel_o);
  // R9
  hi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op != OP_LOAD |=> $stable(addr_o[ADDR_W-1:BURST_BITS]));
  // R11
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_LOAD && take_p && sel_new) |=> wr_block_o && burst_start_o);
  // R12
  desel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_o && op != OP_LOAD) |=> !sel_o);
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 8;
  localparam int BB = 2;

  typedef struct packed {
    logic [7:0] a;
    logic       sp_n, sc_n, adv_n, c1_n, c2, c3_n, ilv;
    logic [7:0] e_a;
    logic       e_sel, e_st, e_wb;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // a     spn  scn  advn c1n  c2   c3n  ilv   e_a    sel  st   wb
    '{8'h45, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 8'h45, 1'b1,1'b1,1'b0}, // R4 R7
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h46, 1'b1,1'b0,1'b0}, // R7
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h47, 1'b1,1'b0,1'b0}, // R7
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h44, 1'b1,1'b0,1'b0}, // R7
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h45, 1'b1,1'b0,1'b0}, // R10
    '{8'hFF, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'h45, 1'b1,1'b0,1'b0}, // R9 wait
    '{8'h9E, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 8'h9E, 1'b1,1'b1,1'b1}, // R2 R11
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h9F, 1'b1,1'b0,1'b0}, // R8 R11
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h9C, 1'b1,1'b0,1'b0}, // R8
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h9D, 1'b1,1'b0,1'b0}, // R8
    '{8'h33, 1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 8'h9E, 1'b1,1'b0,1'b0}, // R3 R10
    '{8'h30, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h30, 1'b0,1'b0,1'b1}, // R2 deselect
    '{8'h55, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h30, 1'b0,1'b0,1'b1}, // R12
    '{8'h77, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 8'h77, 1'b0,1'b0,1'b1}, // R4 ce1 high
    '{8'h12, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 8'h12, 1'b1,1'b1,1'b0}, // R4
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h13, 1'b1,1'b0,1'b0}, // R6
    '{8'h2B, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 8'h2B, 1'b1,1'b1,1'b1}, // R5
    '{8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h28, 1'b1,1'b0,1'b0}  // R7 R11
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, ilv = 1'b0;
  logic [AW-1:0] addr_o;
  logic          sel, bstart, wblk;
  int            n_chk = 0, n_err = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(BB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i),
    .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .ilv_order_i(ilv),
    .addr_o(addr_o), .sel_o(sel), .burst_start_o(bstart), .wr_block_o(wblk)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    addr_i = v.a;  adsp_n = v.sp_n; adsc_n = v.sc_n; adv_n = v.adv_n;
    ce1_n  = v.c1_n; ce2 = v.c2; ce3_n = v.c3_n; ilv = v.ilv;
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 addr", addr_o, 0);
    check("R1 sel", sel, 0);
    check("R1 start", bstart, 0);
    check("R1 wr_block", wblk, 1);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vec%0d addr", i), addr_o, VECS[i].e_a);
      check($sformatf("vec%0d sel", i), sel, VECS[i].e_sel);
      check($sformatf("vec%0d start", i), bstart, VECS[i].e_st);
      check($sformatf("vec%0d wr_block", i), wblk, VECS[i].e_wb);
    end
    // R8 interleaved from start 01: 01,00,11,10
    drive('{8'hC1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1, 8'h0,1'b0,1'b0,1'b0});
    @(posedge clk); @(negedge clk);
    check("R8 beat0", addr_o, 8'hC1);
    adsc_n = 1'b1; adv_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 beat1", addr_o, 8'hC0);
    @(posedge clk); @(negedge clk);
    check("R8 beat2", addr_o, 8'hC3);
    @(posedge clk); @(negedge clk);
    check("R8 beat3", addr_o, 8'hC2);
    @(posedge clk); @(negedge clk);
    check("R10 wrap", addr_o, 8'hC1);
    // R1 asynchronous reset mid-burst
    rst_n = 1'b0;
    #1;
    check("R1 mid addr", addr_o, 0);
    check("R1 mid sel", sel, 0);
    check("R1 mid wr_block", wblk, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule